// File: doc/BRIEF.md
# Prioritising Peripheral Interrupt Concentrator with Acknowledge

This block gathers interrupt events from up to 32 on-chip peripheral sources. It presents one request to a first-level interrupt controller on an output line that software selects. Each event sets a sticky pending bit. A pending vector can raise the request only when four things hold: its mask bit is set, its in-service bit is clear, it outranks every vector already in service, and the global enable is on. Vector 0 is never a source. It is reserved as the error vector.

Software takes an interrupt by writing the acknowledge bit of the vector register. That write captures the highest-ranked eligible vector, clears its pending bit and marks it in service, all on one clock edge. A later read of the vector register returns the captured number. If the request has gone away by acknowledge time, for example because the vector was masked after it was raised, the acknowledge captures the error vector and changes nothing else. The handler ends its service by writing a one to the vector's in-service bit.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask, in-service and vector registers all read zero and every bit of `irq_out` is low.
- R2: Register address 0 is the configuration register, 1 the mask, 2 the in-service register and 3 the vector register. Configuration bit 0 is the global enable, bit 1 the promote enable, bits 12:8 the promoted vector and bits 15:13 the request line. Configuration reads back its 16 bits and the mask reads back its value.
- R3: A high `src_evt[v]` for v ≥ 1 makes vector v pending on that clock edge. `src_evt[0]` has no effect, because vector 0 is reserved as the error vector.
- R4: A vector is eligible when it is pending, its mask bit is set, its in-service bit is clear and it outranks every in-service vector. When the global enable is 1 and some vector is eligible, `irq_out` is one-hot at the bit given by configuration bits 15:13. Otherwise `irq_out` is all zero.
- R5: Among eligible vectors the higher number wins. When the promote enable is set, the vector named in bits 12:8 outranks all others.
- R6: A write to address 3 with data bit 0 set captures the winning vector. Address 3 then reads the vector in bits 15:11, with all other bits zero. A write to address 3 with bit 0 clear has no effect. Acknowledge does not depend on the global enable.
- R7: On the acknowledge edge, the captured vector's pending bit clears and its in-service bit sets. A new event for that vector on the same edge leaves it pending.
- R8: Writing address 2 clears each in-service bit whose data bit is 1 and keeps every bit whose data bit is 0.
- R9: While vectors are in service, only a vector ranked strictly above all of them can raise the request.
- R10: An acknowledge with no eligible vector captures vector 0 and leaves the pending and in-service bits unchanged.
- R11: Clearing a vector's mask bit removes its request from the next cycle on. Writing zero to the mask removes every request.
- R12: With the global enable at 0, `irq_out` stays zero and pending bits are kept. They raise the request again once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source event, sampled each clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | NLVL | One-hot request to the first-level controller |

## Verification
The bench targets four corner cases:
- **Acknowledge after masking.** The bench acknowledges after a vector has been masked. A design that kept a stale winner would hand back a real vector and mark it in service, where the error vector is expected.
- **Nesting rules.** The bench exercises nesting, both with and without promotion. A wrong ceiling comparison either lets a lower vector interrupt its betters or locks out a higher one.
- **Event and acknowledge on the same edge.** This case exposes a design that loses the new event.
- **Selective write-one-to-clear.** A design that cleared the whole register would drop a nested vector still in service.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int VW          = 5;
   localparam int LVLW        = 3;
   localparam int CFG_W       = 16;
   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_PRO_BIT = 1;
   localparam int CFG_SEL_LSB = 8;
   localparam int CFG_LVL_LSB = 13;
   localparam int VEC_LSB     = 11;
   localparam int ACK_BIT     = 0;
   localparam logic [VW-1:0] ERR_VEC = '0;

   typedef enum logic [1:0] {
      REG_CFG  = 2'd0,
      REG_MASK = 2'd1,
      REG_ISR  = 2'd2,
      REG_VEC  = 2'd3
   } pic_reg_e;

   typedef struct packed {
      logic [LVLW-1:0] lvl;
      logic [VW-1:0]   sel;
      logic            promo;
      logic            en;
   } pic_cfg_t;

   function automatic pic_cfg_t cfg_decode(input logic [CFG_W-1:0] raw);
      pic_cfg_t c;
      c.en    = raw[CFG_EN_BIT];
      c.promo = raw[CFG_PRO_BIT];
      c.sel   = raw[CFG_SEL_LSB +: VW];
      c.lvl   = raw[CFG_LVL_LSB +: LVLW];
      return c;
   endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [31:0]       wdata,
   output pic_cfg_t          cfg,
   output logic [CFG_W-1:0]  cfg_raw,
   output logic [NSRC-1:0]   mask,
   output logic              ack_stb,
   output logic [NSRC-1:0]   isr_clr
);

   pic_reg_e sel_reg;
   logic [CFG_W-1:0] cfg_q;
   logic [NSRC-1:0]  mask_q;

   assign sel_reg = pic_reg_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else if (we) begin
         if (sel_reg == REG_CFG)  cfg_q  <= wdata[CFG_W-1:0];
         if (sel_reg == REG_MASK) mask_q <= wdata[NSRC-1:0];
      end
   end

   assign cfg_raw = cfg_q;
   assign cfg     = cfg_decode(cfg_q);
   assign mask    = mask_q;
   assign ack_stb = we && (sel_reg == REG_VEC) && wdata[ACK_BIT];
   assign isr_clr = (we && (sel_reg == REG_ISR)) ? wdata[NSRC-1:0] : '0;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import pic_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic [NSRC-1:0] pend,
   input  logic [NSRC-1:0] mask,
   input  logic [NSRC-1:0] isr,
   input  logic            promo,
   input  logic [VW-1:0]   sel,
   output logic            elig_any,
   output logic [VW-1:0]   win_idx
);

   localparam int RW = VW + 1;

   logic [RW-1:0]   rank [NSRC];
   logic [NSRC-1:0] elig;
   logic            has_isr;
   logic [RW-1:0]   ceil_rank;
   logic [RW-1:0]   best_rank;

   for (genvar v = 0; v < NSRC; v++) begin : g_rank
      assign rank[v] = (promo && (sel == VW'(v))) ? RW'(NSRC) : RW'(v);
      assign elig[v] = pend[v] & mask[v] & ~isr[v] &
                       (~has_isr | (rank[v] > ceil_rank));
   end

   // highest rank currently in service
   always_comb begin
      has_isr   = 1'b0;
      ceil_rank = '0;
      for (int v = 0; v < NSRC; v++) begin
         if (isr[v] && (!has_isr || rank[v] > ceil_rank)) begin
            has_isr   = 1'b1;
            ceil_rank = rank[v];
         end
      end
   end

   // highest-ranked eligible vector
   always_comb begin
      elig_any  = 1'b0;
      win_idx   = ERR_VEC;
      best_rank = '0;
      for (int v = 0; v < NSRC; v++) begin
         if (elig[v] && (!elig_any || rank[v] > best_rank)) begin
            elig_any  = 1'b1;
            win_idx   = VW'(v);
            best_rank = rank[v];
         end
      end
   end

endmodule

// File: rtl/pic_state.sv
module pic_state
   import pic_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic            ack_stb,
   input  logic            elig_any,
   input  logic [VW-1:0]   win_idx,
   input  logic [NSRC-1:0] isr_clr,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] isr,
   output logic [VW-1:0]   vec
);

   logic [NSRC-1:0] ack_set;
   logic [NSRC-1:0] isr_q;
   logic [VW-1:0]   vec_q;

   assign ack_set = (ack_stb && elig_any) ? (NSRC'(1) << win_idx) : '0;

   for (genvar v = 0; v < NSRC; v++) begin : g_pend
      if (v == int'(ERR_VEC)) begin : g_rsv
         logic unused_src;
         assign unused_src = src[v];
         assign pend[v]    = 1'b0;
      end else begin : g_src
         logic pq;
         always_ff @(posedge clk) begin
            if (!rst_n) pq <= 1'b0;
            else        pq <= (pq & ~ack_set[v]) | src[v];
         end
         assign pend[v] = pq;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q <= '0;
         vec_q <= ERR_VEC;
      end else begin
         isr_q <= (isr_q & ~isr_clr) | ack_set;
         if (ack_stb) vec_q <= elig_any ? win_idx : ERR_VEC;
      end
   end

   assign isr = isr_q;
   assign vec = vec_q;

endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int NLVL = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_evt,
   input  logic            reg_we,
   input  logic [1:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic [NLVL-1:0] irq_out
);

   if (NSRC < 2 || NSRC > (1 << VW)) begin : g_bad_nsrc
      $error("NSRC must lie between 2 and 32");
   end
   if (NLVL < 1 || NLVL > (1 << LVLW)) begin : g_bad_nlvl
      $error("NLVL must lie between 1 and 8");
   end

   pic_cfg_t         cfg_q;
   logic [CFG_W-1:0] cfg_raw;
   logic [NSRC-1:0]  mask_q;
   logic [NSRC-1:0]  isr_clr;
   logic             ack_stb;
   logic [NSRC-1:0]  pend_q;
   logic [NSRC-1:0]  isr_q;
   logic [VW-1:0]    vec_q;
   logic             elig_any;
   logic [VW-1:0]    win_idx;
   logic             req;

   pic_regs #(.NSRC(NSRC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .cfg     (cfg_q),
      .cfg_raw (cfg_raw),
      .mask    (mask_q),
      .ack_stb (ack_stb),
      .isr_clr (isr_clr)
   );

   pic_arbiter #(.NSRC(NSRC)) u_arb (
      .pend     (pend_q),
      .mask     (mask_q),
      .isr      (isr_q),
      .promo    (cfg_q.promo),
      .sel      (cfg_q.sel),
      .elig_any (elig_any),
      .win_idx  (win_idx)
   );

   pic_state #(.NSRC(NSRC)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_evt),
      .ack_stb  (ack_stb),
      .elig_any (elig_any),
      .win_idx  (win_idx),
      .isr_clr  (isr_clr),
      .pend     (pend_q),
      .isr      (isr_q),
      .vec      (vec_q)
   );

   assign req = cfg_q.en && elig_any;

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      assign irq_out[l] = req && (cfg_q.lvl == LVLW'(l));
   end

   always_comb begin
      unique case (pic_reg_e'(reg_addr))
         REG_CFG:  reg_rdata = 32'(cfg_raw);
         REG_MASK: reg_rdata = 32'(mask_q);
         REG_ISR:  reg_rdata = 32'(isr_q);
         REG_VEC:  reg_rdata = 32'({vec_q, {VEC_LSB{1'b0}}});
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/periph_irq_ctrl_chk.sv
module periph_irq_ctrl_chk
   import pic_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int NLVL = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic [1:0]      reg_addr,
   input logic [31:0]     reg_wdata,
   input logic [NLVL-1:0] irq_out,
   input logic            cfg_en,
   input logic [NSRC-1:0] isr,
   input logic            elig_any,
   input logic [VW-1:0]   win_idx,
   input logic [VW-1:0]   vec
);

   logic ack;
   assign ack = reg_we && (reg_addr == 2'd3) && reg_wdata[ACK_BIT];

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_out));

   p_quiet_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> (irq_out == '0));

   p_ack_captures_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && elig_any) |=> (isr[$past(win_idx)] && (vec == $past(win_idx))));

   p_err_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !elig_any) |=> ((vec == ERR_VEC) && (isr == $past(isr))));

   p_mask_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1 && reg_wdata[NSRC-1:0] == '0) |=> (irq_out == '0));

   p_isr_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd2) |=> ((isr & $past(reg_wdata[NSRC-1:0])) == '0));

endmodule

bind periph_irq_ctrl periph_irq_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_out   (irq_out),
   .cfg_en    (cfg_q.en),
   .isr       (isr_q),
   .elig_any  (elig_any),
   .win_idx   (win_idx),
   .vec       (vec_q)
);

// File: tb/periph_irq_ctrl_tb.sv
`timescale 1ns/1ps
module periph_irq_ctrl_tb;

   localparam int NSRC = 32;
   localparam int NLVL = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_evt = '0;
   logic            reg_we = 1'b0;
   logic [1:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NLVL-1:0] irq_out;

   always #2.5 clk = ~clk;

   periph_irq_ctrl #(.NSRC(NSRC), .NLVL(NLVL)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference state
   logic [15:0] m_cfg = '0;
   logic [31:0] m_mask = '0, m_isr = '0, m_pend = '0;
   int          m_vec = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_rank(input int v);
      if (m_cfg[1] && int'(m_cfg[12:8]) == v) return 1000;
      return v;
   endfunction

   function automatic int m_winner();
      int ceil_r = -1;
      int best = -1;
      int best_r = -1;
      for (int v = 0; v < NSRC; v++)
         if (m_isr[v] && m_rank(v) > ceil_r) ceil_r = m_rank(v);
      for (int v = 0; v < NSRC; v++)
         if (m_pend[v] && m_mask[v] && !m_isr[v] && m_rank(v) > ceil_r && m_rank(v) > best_r) begin
            best = v;
            best_r = m_rank(v);
         end
      return best;
   endfunction

   function automatic logic [31:0] m_irq();
      if (m_cfg[0] && m_winner() >= 0 && int'(m_cfg[15:13]) < NLVL)
         return 32'(1) << m_cfg[15:13];
      return '0;
   endfunction

   function automatic logic [31:0] m_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {16'h0, m_cfg};
         2'd1:    return m_mask;
         2'd2:    return m_isr;
         default: return 32'(m_vec) << 11;
      endcase
   endfunction

   task automatic m_update(input logic we, input logic [1:0] a, input logic [31:0] d,
                           input logic [31:0] s);
      int w;
      w = m_winner();
      if (we) begin
         case (a)
            2'd0: m_cfg = d[15:0];
            2'd1: m_mask = d;
            2'd2: m_isr = m_isr & ~d;
            default: if (d[0]) begin
               if (w >= 0) begin
                  m_vec = w;
                  m_pend[w] = 1'b0;
                  m_isr[w] = 1'b1;
               end else m_vec = 0;
            end
         endcase
      end
      m_pend = m_pend | (s & 32'hFFFF_FFFE);
   endtask

   // one clock: drive at negedge, compare outputs, advance model at posedge
   task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic [31:0] s);
      reg_we = we; reg_addr = a; reg_wdata = d; src_evt = s;
      #1;
      chk("R4 irq_out vs model", 32'(irq_out), m_irq());
      chk("R2 read data vs model", reg_rdata, m_rd(a));
      @(posedge clk);
      m_update(we, a, d, s);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, '0);
   endtask

   task automatic ev(input logic [31:0] s);
      cyc(1'b0, 2'd0, '0, s);
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      reg_we = 1'b0; reg_addr = a; src_evt = '0;
      #1;
      chk(tag, reg_rdata, exp);
      cyc(1'b0, a, '0, '0);
   endtask

   task automatic chk_irq(input logic [31:0] exp, input string tag);
      #1;
      chk(tag, 32'(irq_out), exp);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired (all requirements)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_irq(0, "R1 irq after reset");
      rd(2'd0, 0, "R1 cfg after reset");
      rd(2'd1, 0, "R1 mask after reset");
      rd(2'd2, 0, "R1 isr after reset");
      rd(2'd3, 0, "R1 vector after reset");
      // R2 setup: all unmasked, enabled, line 2
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0000_4001);
      rd(2'd0, 32'h4001, "R2 cfg readback");
      rd(2'd1, 32'hFFFF_FFFF, "R2 mask readback");
      // R3 source 0 reserved
      ev(32'h1);
      chk_irq(0, "R3 src 0 ignored");
      // R4 / R5 / R6
      ev((32'd1 << 5) | (32'd1 << 9));
      chk_irq(32'h4, "R4 request on line 2");
      wr(2'd3, 32'h1);
      rd(2'd3, 32'd9 << 11, "R5 higher vector wins, R6 vector in 15:11");
      rd(2'd2, 32'd1 << 9, "R7 isr set on ack");
      chk_irq(0, "R9 lower vector blocked by in-service");
      ev(32'd1 << 12);
      chk_irq(32'h4, "R9 higher vector may nest");
      wr(2'd2, 32'd1 << 9);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'd12 << 11, "R5 vector 12 taken");
      wr(2'd2, 32'd1 << 12);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'd5 << 11, "R7 vector 5 taken after 9 cleared");
      wr(2'd2, 32'd1 << 5);
      // R8 selective clear
      ev((32'd1 << 7) | (32'd1 << 3));
      wr(2'd3, 32'h1);
      ev(32'd1 << 20);
      wr(2'd3, 32'h1);
      rd(2'd2, (32'd1 << 7) | (32'd1 << 20), "R8 two in service");
      wr(2'd2, 32'd1 << 7);
      rd(2'd2, 32'd1 << 20, "R8 only written bit cleared");
      wr(2'd2, 32'd1 << 20);
      // R5 promotion of vector 3
      wr(2'd0, 32'h0000_4303);
      ev(32'd1 << 25);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'd3 << 11, "R5 promoted vector wins");
      chk_irq(0, "R9 promoted in service blocks vector 25");
      wr(2'd2, 32'd1 << 3);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'd25 << 11, "R5 vector 25 after promoted");
      wr(2'd2, 32'd1 << 25);
      wr(2'd0, 32'h0000_4001);
      // R11 / R10 masking and error vector
      ev(32'd1 << 6);
      chk_irq(32'h4, "R4 vector 6 requests");
      wr(2'd1, ~(32'd1 << 6));
      chk_irq(0, "R11 masked request dropped");
      wr(2'd3, 32'h1);
      rd(2'd3, 32'h0, "R10 error vector");
      rd(2'd2, 32'h0, "R10 isr unchanged");
      wr(2'd1, 32'hFFFF_FFFF);
      chk_irq(32'h4, "R10 pending kept through error ack");
      wr(2'd1, 32'h0);
      chk_irq(0, "R11 zero mask drops all");
      wr(2'd1, 32'hFFFF_FFFF);
      // R12 global enable
      wr(2'd0, 32'h0000_4000);
      chk_irq(0, "R12 disabled");
      wr(2'd0, 32'h0000_4001);
      chk_irq(32'h4, "R12 pending kept while disabled");
      wr(2'd0, 32'h0000_E001);
      chk_irq(32'h80, "R4 request line 7");
      wr(2'd3, 32'h1);
      wr(2'd2, 32'd1 << 6);
      // R6 write without ack bit
      ev(32'd1 << 10);
      wr(2'd3, 32'h0000_FFFE);
      rd(2'd3, 32'd6 << 11, "R6 no ack bit, vector kept");
      rd(2'd2, 32'h0, "R6 no ack bit, isr kept");
      wr(2'd3, 32'h1);
      wr(2'd2, 32'd1 << 10);
      // R7 event on the acknowledge edge
      ev(32'd1 << 11);
      cyc(1'b1, 2'd3, 32'h1, 32'd1 << 11);
      rd(2'd2, 32'd1 << 11, "R7 isr set with same-edge event");
      wr(2'd2, 32'd1 << 11);
      chk_irq(32'h80, "R7 same-edge event stays pending");
      wr(2'd3, 32'h1);
      wr(2'd2, 32'd1 << 11);
      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] d;
         logic [1:0]  a;
         a = 2'($urandom_range(0, 3));
         d = $urandom;
         if (a == 2'd0) d = (d & 32'h0000_FF03) | 32'h1;
         if (a == 2'd1 && ($urandom_range(0, 3) != 0)) d = d | 32'hFFFF_0000;
         cyc(($urandom_range(0, 2) == 0), a, d, $urandom & $urandom & $urandom);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule